// File: doc/BRIEF.md
# USB endpoint handshake responder

This block picks the handshake that a USB 2.0 device returns on each of its OUT-capable endpoints when the host sends a SETUP, an OUT with data, or a PING. Its inputs are already-decoded token events: the token kind, the target endpoint, whether the data CRC was good, and the payload length with the CRC bytes removed. It also takes a speed flag and two buffer-space indications per endpoint. It returns ACK, NAK, NYET, STALL or nothing. It raises a write strobe when the payload should be kept in the endpoint buffer.

Each endpoint holds three control bits written by firmware (interrupt enable, NYET suppression, stall request) and two event flags (setup received, stall sent). It also holds the length of the last accepted packet. A small register port lets firmware write the control bits, clear flags by writing ones, and read back the control and status words. The interrupt line is high while any endpoint has its interrupt enabled and a received setup that firmware has not yet cleared.

The handshake and write strobe are registered. They appear one clock after the token is presented, and the status changes on that same edge.

Top module: `usb_ep_handshake`

## Requirements
- R1: After a synchronous reset, `hs_code` is 0 (none), `buf_we` and `irq` are low, and every endpoint reads all-zero control and status.
- R2: A SETUP with good CRC on an endpoint whose setup flag is clear is answered with ACK (code 1) and a write strobe, whatever buffer space is reported. The setup flag (status bit 0) is set, and the byte count (status bits LEN_W+1:2) takes `tok_len`.
- R3: While an endpoint's setup flag is set, nothing further is accepted on it. An OUT gets NAK (code 2) and a PING gets NAK. A SETUP gets no handshake. No write strobe is raised and the byte count is unchanged.
- R4: A register write at address 1 clears the setup flag when data bit 0 is 1, and clears the stall-sent flag when data bit 1 is 1. Bits written as 0 leave the flags unchanged.
- R5: `irq` is high exactly when some endpoint has its control bit 0 (interrupt enable) set and its setup flag set.
- R6: With control bit 2 (stall request) set, an OUT with good CRC or a high-speed PING is answered with STALL (code 4) and sets the stall-sent flag (status bit 1). A following accepted SETUP clears that flag and is answered with ACK.
- R7: In high-speed mode, an OUT with good CRC that has room (`room_one`) is written. It is answered with NYET (code 3) if `room_two` is low, and with ACK otherwise.
- R8: With `hs_mode` low, NYET is never returned; an OUT that would take NYET at high speed gets ACK.
- R9: With control bit 1 (NYET suppression) set, the endpoint answers ACK where it would otherwise answer NYET.
- R10: A high-speed PING is answered with ACK if `room_one` is high and with NAK if it is low. At full speed a PING gets no handshake.
- R11: An OUT or SETUP with bad data CRC gets no handshake and no write strobe, and leaves the byte count unchanged.
- R12: An OUT with good CRC on an unlocked, unstalled endpoint whose `room_one` is low is answered with NAK, and the payload is discarded (no write strobe).
- R13: When a flag-clear write and an event that sets the same flag arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | A decoded token is present this cycle |
| tok_kind | input | 2 | 0 SETUP, 1 OUT with data, 2 PING, 3 ignored |
| tok_ep | input | EPW | Target endpoint index |
| tok_crc_ok | input | 1 | Data CRC of the packet was good |
| tok_len | input | LEN_W | Payload length without CRC bytes |
| hs_mode | input | 1 | Device runs at high speed |
| room_one | input | NUM_EP | Per endpoint: space for one maximum-size payload |
| room_two | input | NUM_EP | Per endpoint: space for that payload and one more |
| csr_we | input | 1 | Register write strobe |
| csr_ep | input | EPW | Endpoint selected by the register port |
| csr_addr | input | 2 | 0 control, 1 flag clear, 2 status |
| csr_wdata | input | 3 | Write data (control bits or clear mask) |
| csr_rdata | output | LEN_W+2 | Read data for the selected endpoint and address |
| hs_code | output | 3 | Handshake: 0 none, 1 ACK, 2 NAK, 3 NYET, 4 STALL |
| buf_we | output | 1 | Store the payload into the endpoint buffer |
| buf_ep | output | EPW | Endpoint for the write strobe |
| irq | output | 1 | Endpoint interrupt |

## Verification
A firmware flag-clear write and a token that sets the same flag can land on the same endpoint in the same cycle. This can happen with a setup acceptance against a setup-flag clear, or with a stall response against a stall-flag clear. The bench drives both in one cycle on purpose and then reads the status word, which must show the flag still set. Random traffic repeats this collision many times. The behavioural model applies clears first and sets last, and every cycle it compares the handshake, the strobe, the interrupt and the read data.

// File: rtl/usb_hs_pkg.sv
`timescale 1ns/1ps
package usb_hs_pkg;

    typedef enum logic [1:0] {
        TK_SETUP = 2'd0,
        TK_OUT   = 2'd1,
        TK_PING  = 2'd2,
        TK_RSVD  = 2'd3
    } tok_kind_e;

    typedef enum logic [2:0] {
        HS_NONE  = 3'd0,
        HS_ACK   = 3'd1,
        HS_NAK   = 3'd2,
        HS_NYET  = 3'd3,
        HS_STALL = 3'd4
    } hs_code_e;

    localparam int CTRL_BITS = 3;

    localparam logic [1:0] CSR_CTRL = 2'd0;
    localparam logic [1:0] CSR_CLR  = 2'd1;
    localparam logic [1:0] CSR_STAT = 2'd2;

    // control word written by firmware
    typedef struct packed {
        logic stall_req;
        logic nyet_off;
        logic irq_en;
    } ep_ctrl_t;

    // event flags raised by the responder
    typedef struct packed {
        logic stall_sent;
        logic setup_rcvd;
    } ep_flags_t;

    typedef struct packed {
        hs_code_e code;
        logic     write;
        logic     set_setup;
        logic     set_stall;
        logic     clr_stall;
    } verdict_t;

    // handshake decision for one token on one endpoint
    function automatic verdict_t judge(
        input tok_kind_e kind,
        input logic      crc_ok,
        input logic      hs,
        input logic      room1,
        input logic      room2,
        input ep_ctrl_t  c,
        input ep_flags_t f
    );
        verdict_t v;
        v      = '0;
        v.code = HS_NONE;
        case (kind)
            TK_SETUP: begin
                if (crc_ok && !f.setup_rcvd) begin
                    v.code      = HS_ACK;
                    v.write     = 1'b1;
                    v.set_setup = 1'b1;
                    v.clr_stall = 1'b1;
                end
            end
            TK_OUT: begin
                if (crc_ok) begin
                    if (c.stall_req) begin
                        v.code      = HS_STALL;
                        v.set_stall = 1'b1;
                    end else if (f.setup_rcvd || !room1) begin
                        v.code = HS_NAK;
                    end else begin
                        v.write = 1'b1;
                        v.code  = (hs && !c.nyet_off && !room2) ? HS_NYET : HS_ACK;
                    end
                end
            end
            TK_PING: begin
                if (hs) begin
                    if (c.stall_req) begin
                        v.code      = HS_STALL;
                        v.set_stall = 1'b1;
                    end else if (f.setup_rcvd || !room1) begin
                        v.code = HS_NAK;
                    end else begin
                        v.code = HS_ACK;
                    end
                end
            end
            default: ;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ep_decide.sv
`timescale 1ns/1ps
module ep_decide
    import usb_hs_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int EPW    = 2
) (
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic [EPW-1:0]    tok_ep,
    input  logic              tok_crc_ok,
    input  logic              hs_mode,
    input  logic [NUM_EP-1:0] room_one,
    input  logic [NUM_EP-1:0] room_two,
    input  ep_ctrl_t          ctrl_all  [NUM_EP],
    input  ep_flags_t         flags_all [NUM_EP],
    output verdict_t          verdict,
    output logic [NUM_EP-1:0] ep_sel
);

    for (genvar i = 0; i < NUM_EP; i++) begin : g_sel
        assign ep_sel[i] = tok_valid && (tok_ep == EPW'(i));
    end

    always_comb begin
        verdict      = '0;
        verdict.code = HS_NONE;
        if (tok_valid) begin
            verdict = judge(tok_kind_e'(tok_kind), tok_crc_ok, hs_mode,
                            room_one[tok_ep], room_two[tok_ep],
                            ctrl_all[tok_ep], flags_all[tok_ep]);
        end
    end

endmodule

// File: rtl/ep_state.sv
`timescale 1ns/1ps
module ep_state
    import usb_hs_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel,
    input  verdict_t             verdict,
    input  logic [LEN_W-1:0]     tok_len,
    input  logic                 csr_hit,
    input  logic [1:0]           csr_addr,
    input  logic [CTRL_BITS-1:0] csr_wdata,
    output ep_ctrl_t             ctrl_q,
    output ep_flags_t            flags_q,
    output logic [LEN_W-1:0]     count_q
);

    logic      clr_setup;
    logic      clr_stall_fw;
    ep_flags_t flags_n;

    assign clr_setup    = csr_hit && (csr_addr == CSR_CLR) && csr_wdata[0];
    assign clr_stall_fw = csr_hit && (csr_addr == CSR_CLR) && csr_wdata[1];

    // clears first, events last: a same-cycle event wins
    always_comb begin
        flags_n = flags_q;
        if (clr_setup)    flags_n.setup_rcvd = 1'b0;
        if (clr_stall_fw) flags_n.stall_sent = 1'b0;
        if (sel && verdict.clr_stall) flags_n.stall_sent = 1'b0;
        if (sel && verdict.set_stall) flags_n.stall_sent = 1'b1;
        if (sel && verdict.set_setup) flags_n.setup_rcvd = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            flags_q <= '0;
            count_q <= '0;
        end else begin
            if (csr_hit && (csr_addr == CSR_CTRL)) ctrl_q <= ep_ctrl_t'(csr_wdata);
            flags_q <= flags_n;
            if (sel && verdict.write) count_q <= tok_len;
        end
    end

    AST_STALL_MARKED: assert property (@(posedge clk) disable iff (rst)
        (sel && verdict.set_stall) |=> flags_q.stall_sent); // R6

    AST_SETUP_HELD: assert property (@(posedge clk) disable iff (rst)
        (flags_q.setup_rcvd && !clr_setup) |=> flags_q.setup_rcvd); // R3

    AST_SETUP_WINS: assert property (@(posedge clk) disable iff (rst)
        (sel && verdict.set_setup && clr_setup) |=> flags_q.setup_rcvd); // R13

    AST_COUNT_KEPT: assert property (@(posedge clk) disable iff (rst)
        !(sel && verdict.write) |=> $stable(count_q)); // R11

endmodule

// File: rtl/usb_ep_handshake.sv
`timescale 1ns/1ps
module usb_ep_handshake
    import usb_hs_pkg::*;
#(
    parameter  int NUM_EP = 4,
    parameter  int LEN_W  = 11,
    localparam int EPW    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
    localparam int CSR_W  = LEN_W + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tok_valid,
    input  logic [1:0]           tok_kind,
    input  logic [EPW-1:0]       tok_ep,
    input  logic                 tok_crc_ok,
    input  logic [LEN_W-1:0]     tok_len,
    input  logic                 hs_mode,
    input  logic [NUM_EP-1:0]    room_one,
    input  logic [NUM_EP-1:0]    room_two,
    input  logic                 csr_we,
    input  logic [EPW-1:0]       csr_ep,
    input  logic [1:0]           csr_addr,
    input  logic [CTRL_BITS-1:0] csr_wdata,
    output logic [CSR_W-1:0]     csr_rdata,
    output logic [2:0]           hs_code,
    output logic                 buf_we,
    output logic [EPW-1:0]       buf_ep,
    output logic                 irq
);

    ep_ctrl_t          ctrl_all  [NUM_EP];
    ep_flags_t         flags_all [NUM_EP];
    logic [LEN_W-1:0]  count_all [NUM_EP];
    verdict_t          verdict;
    logic [NUM_EP-1:0] ep_sel;

    hs_code_e          hs_q;
    logic              we_q;
    logic [EPW-1:0]    ep_q;

    ep_decide #(.NUM_EP(NUM_EP), .EPW(EPW)) u_decide (
        .tok_valid  (tok_valid),
        .tok_kind   (tok_kind),
        .tok_ep     (tok_ep),
        .tok_crc_ok (tok_crc_ok),
        .hs_mode    (hs_mode),
        .room_one   (room_one),
        .room_two   (room_two),
        .ctrl_all   (ctrl_all),
        .flags_all  (flags_all),
        .verdict    (verdict),
        .ep_sel     (ep_sel)
    );

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        ep_state #(.LEN_W(LEN_W)) u_state (
            .clk       (clk),
            .rst       (rst),
            .sel       (ep_sel[i]),
            .verdict   (verdict),
            .tok_len   (tok_len),
            .csr_hit   (csr_we && (csr_ep == EPW'(i))),
            .csr_addr  (csr_addr),
            .csr_wdata (csr_wdata),
            .ctrl_q    (ctrl_all[i]),
            .flags_q   (flags_all[i]),
            .count_q   (count_all[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q <= HS_NONE;
            we_q <= 1'b0;
            ep_q <= '0;
        end else begin
            hs_q <= verdict.code;
            we_q <= verdict.write;
            ep_q <= tok_ep;
        end
    end

    assign hs_code = hs_q;
    assign buf_we  = we_q;
    assign buf_ep  = ep_q;

    always_comb begin
        irq = 1'b0;
        for (int i = 0; i < NUM_EP; i++) begin
            irq = irq | (ctrl_all[i].irq_en & flags_all[i].setup_rcvd);
        end
    end

    always_comb begin
        csr_rdata = '0;
        case (csr_addr)
            CSR_CTRL: csr_rdata[CTRL_BITS-1:0] = ctrl_all[csr_ep];
            CSR_STAT: csr_rdata = {count_all[csr_ep], flags_all[csr_ep]};
            default:  csr_rdata = '0;
        endcase
    end

    AST_FS_NO_NYET: assert property (@(posedge clk) disable iff (rst)
        (hs_q == HS_NYET) |-> $past(hs_mode)); // R8

    AST_NYET_SUPPRESSED: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && ctrl_all[tok_ep].nyet_off) |=> (hs_q != HS_NYET)); // R9

    AST_BAD_CRC_QUIET: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && (tok_kind != TK_PING) && !tok_crc_ok) |=> (!we_q && hs_q == HS_NONE)); // R11

    AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && tok_kind == TK_OUT && !room_one[tok_ep]) |=> !we_q); // R12

    AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && flags_all[tok_ep].setup_rcvd) |=> !we_q); // R3

endmodule

// File: tb/tb_usb_ep_handshake.sv
`timescale 1ns/1ps
module tb_usb_ep_handshake;

    localparam int CLK_P  = 10;
    localparam int NUM_EP = 4;
    localparam int LEN_W  = 11;
    localparam int EPW    = 2;
    localparam int CSR_W  = LEN_W + 2;

    logic              clk = 0;
    logic              rst = 1;
    logic              tok_valid = 0;
    logic [1:0]        tok_kind = 0;
    logic [EPW-1:0]    tok_ep = 0;
    logic              tok_crc_ok = 0;
    logic [LEN_W-1:0]  tok_len = 0;
    logic              hs_mode = 0;
    logic [NUM_EP-1:0] room_one = '1;
    logic [NUM_EP-1:0] room_two = '1;
    logic              csr_we = 0;
    logic [EPW-1:0]    csr_ep = 0;
    logic [1:0]        csr_addr = 2;
    logic [2:0]        csr_wdata = 0;
    logic [CSR_W-1:0]  csr_rdata;
    logic [2:0]        hs_code;
    logic              buf_we;
    logic [EPW-1:0]    buf_ep;
    logic              irq;

    usb_ep_handshake #(.NUM_EP(NUM_EP), .LEN_W(LEN_W)) dut (.*);

    always #(CLK_P/2) clk = ~clk;

    // reference model state
    bit  m_irqen [NUM_EP];
    bit  m_nyoff [NUM_EP];
    bit  m_stq   [NUM_EP];
    bit  m_setup [NUM_EP];
    bit  m_stall [NUM_EP];
    int  m_cnt   [NUM_EP];
    int  e_code, e_we, e_ep;
    bit  started = 0;
    bit  done = 0;
    int  n_chk = 0, n_fail = 0;
    string tag = "R1";

    always @(posedge clk) begin
        int e, c, w;
        bit s_setup, s_stall, c_stall;
        started = 1;
        if (rst) begin
            for (int i = 0; i < NUM_EP; i++) begin
                m_irqen[i] = 0; m_nyoff[i] = 0; m_stq[i] = 0;
                m_setup[i] = 0; m_stall[i] = 0; m_cnt[i] = 0;
            end
            e_code = 0; e_we = 0; e_ep = 0;
        end else begin
            e = tok_ep; c = 0; w = 0;
            s_setup = 0; s_stall = 0; c_stall = 0;
            if (tok_valid) begin
                if (tok_kind == 0) begin
                    if (tok_crc_ok && !m_setup[e]) begin
                        c = 1; w = 1; s_setup = 1; c_stall = 1;
                    end
                end else if (tok_kind == 1 && tok_crc_ok) begin
                    if (m_stq[e]) begin c = 4; s_stall = 1; end
                    else if (m_setup[e] || !room_one[e]) c = 2;
                    else begin
                        w = 1;
                        c = (hs_mode && !m_nyoff[e] && !room_two[e]) ? 3 : 1;
                    end
                end else if (tok_kind == 2 && hs_mode) begin
                    if (m_stq[e]) begin c = 4; s_stall = 1; end
                    else if (m_setup[e] || !room_one[e]) c = 2;
                    else c = 1;
                end
            end
            if (csr_we && csr_addr == 0) begin
                m_irqen[csr_ep] = csr_wdata[0];
                m_nyoff[csr_ep] = csr_wdata[1];
                m_stq[csr_ep]   = csr_wdata[2];
            end
            if (csr_we && csr_addr == 1) begin
                if (csr_wdata[0]) m_setup[csr_ep] = 0;
                if (csr_wdata[1]) m_stall[csr_ep] = 0;
            end
            if (c_stall) m_stall[e] = 0;
            if (s_stall) m_stall[e] = 1;
            if (s_setup) m_setup[e] = 1;
            if (w) m_cnt[e] = tok_len;
            e_code = c; e_we = w; e_ep = e;
        end
    end

    task automatic chk(input bit ok, input string what, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            int ei, er;
            ei = 0;
            for (int i = 0; i < NUM_EP; i++) ei = ei | (m_irqen[i] & m_setup[i]);
            case (csr_addr)
                2'd0: er = {m_stq[csr_ep], m_nyoff[csr_ep], m_irqen[csr_ep]};
                2'd2: er = (m_cnt[csr_ep] << 2) | (m_stall[csr_ep] << 1) | m_setup[csr_ep];
                default: er = 0;
            endcase
            chk(int'(hs_code) == e_code, "hs_code", int'(hs_code), e_code);
            chk(int'(buf_we) == e_we, "buf_we", int'(buf_we), e_we);
            if (e_we == 1) chk(int'(buf_ep) == e_ep, "buf_ep", int'(buf_ep), e_ep);
            chk(int'(irq) == ei, "irq (R5)", int'(irq), ei);
            chk(int'(csr_rdata) == er, "csr_rdata", int'(csr_rdata), er);
        end
    end

    task automatic tok(input int k, input int ep, input bit crc, input int len);
        @(negedge clk); #1;
        tok_valid = 1; tok_kind = 2'(k); tok_ep = EPW'(ep);
        tok_crc_ok = crc; tok_len = LEN_W'(len);
        @(posedge clk); #1;
        tok_valid = 0;
    endtask

    task automatic wr(input int ep, input int a, input int d);
        @(negedge clk); #1;
        csr_we = 1; csr_ep = EPW'(ep); csr_addr = 2'(a); csr_wdata = 3'(d);
        @(posedge clk); #1;
        csr_we = 0; csr_addr = 2;
    endtask

    task automatic both(input int k, input int ep, input int len, input int d);
        @(negedge clk); #1;
        tok_valid = 1; tok_kind = 2'(k); tok_ep = EPW'(ep);
        tok_crc_ok = 1; tok_len = LEN_W'(len);
        csr_we = 1; csr_ep = EPW'(ep); csr_addr = 1; csr_wdata = 3'(d);
        @(posedge clk); #1;
        tok_valid = 0; csr_we = 0; csr_addr = 2;
    endtask

    task automatic look(input int ep, input int a);
        @(negedge clk); #1;
        csr_ep = EPW'(ep); csr_addr = 2'(a);
        @(posedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tag = "R1";
        repeat (3) @(posedge clk);
        #1 rst = 0;
        for (int i = 0; i < NUM_EP; i++) look(i, 2);
        look(0, 0);

        tag = "R5";
        wr(0, 0, 1);
        look(0, 2);
        tag = "R2";
        room_one = '0;
        tok(0, 0, 1, 8);
        look(0, 2);
        room_one = '1;

        tag = "R3";
        hs_mode = 1;
        tok(1, 0, 1, 5);
        tok(0, 0, 1, 9);
        tok(2, 0, 1, 0);
        look(0, 2);

        tag = "R4";
        wr(0, 1, 0);
        look(0, 2);
        wr(0, 1, 1);
        look(0, 2);

        tag = "R7";
        room_two = 4'b1101;
        tok(1, 1, 1, 512);
        room_two = '1;
        tok(1, 1, 1, 511);
        look(1, 2);

        tag = "R8";
        hs_mode = 0; room_two = '0;
        tok(1, 1, 1, 64);
        tag = "R10";
        tok(2, 1, 1, 0);

        tag = "R9";
        hs_mode = 1;
        wr(1, 0, 2);
        tok(1, 1, 1, 100);
        room_two = '1;

        tag = "R10";
        tok(2, 2, 1, 0);
        room_one = 4'b1011;
        tok(2, 2, 1, 0);

        tag = "R12";
        tok(1, 2, 1, 33);
        look(2, 2);
        room_one = '1;

        tag = "R11";
        tok(1, 2, 0, 44);
        tok(0, 2, 0, 45);
        look(2, 2);

        tag = "R6";
        wr(2, 0, 4);
        tok(1, 2, 1, 7);
        look(2, 2);
        tok(2, 2, 1, 0);
        wr(2, 0, 0);
        tok(0, 2, 1, 8);
        look(2, 2);
        wr(2, 1, 1);

        tag = "R13";
        wr(3, 0, 5);
        both(0, 3, 12, 1);
        look(3, 2);
        wr(3, 1, 1);
        both(1, 3, 20, 2);
        look(3, 2);
        wr(3, 0, 0);

        tag = "R4";
        wr(3, 1, 3);
        look(3, 2);

        for (int n = 0; n < 3000; n++) begin
            @(negedge clk); #1;
            tok_valid  = ($urandom_range(0, 3) != 0);
            tok_kind   = 2'($urandom_range(0, 3));
            tok_ep     = EPW'($urandom_range(0, NUM_EP - 1));
            tok_crc_ok = ($urandom_range(0, 7) != 0);
            tok_len    = LEN_W'($urandom_range(0, 1024));
            hs_mode    = ($urandom_range(0, 3) != 0);
            room_one   = NUM_EP'($urandom);
            room_two   = NUM_EP'($urandom);
            csr_we     = ($urandom_range(0, 3) == 0);
            csr_ep     = EPW'($urandom_range(0, NUM_EP - 1));
            csr_addr   = 2'($urandom_range(0, 3));
            csr_wdata  = 3'($urandom_range(0, 7));
            if (tok_kind == 0) tag = "R2";
            else if (tok_kind == 1) tag = "R7";
            else tag = "R10";
        end
        @(negedge clk); #1;
        tok_valid = 0; csr_we = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); #1;

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule